// File: doc/BRIEF.md
# OLED Controller Configuration Sequencer

This block brings up a monochrome, page-organized OLED panel controller. A one-cycle start pulse first drives an active-high panel reset for a programmable number of clock cycles, holds it low for the same number of cycles, and then sends the full configuration command stream. Every command byte and every option byte is a separate item on a byte-wide valid/ready output. A flag marks each item as a command byte and not pixel data.

The configuration values are static inputs held by the surrounding logic: contrast, segment and COM-scan remap, panel height, COM offset, clock divider and frequency code, the two precharge phases, the COM pin options, the VCOMH level, the charge-pump need and the addressing mode. When the stream is complete, `done` rises and stays high until the next accepted start. While the block is idle, single-byte display-on and display-off requests are also served.

Top module: `oled_cfg_seq`

## Requirements
- R1: An accepted start drives `panel_rst` high for exactly RST_CYCLES cycles, then low for exactly RST_CYCLES cycles with `tx_valid` low, after which the first byte is offered.
- R2: The first two bytes are 0x81 and then `contrast`.
- R3: Next come 0xA0 with `seg_remap` in bit 0, then 0xC0 with `com_invert` in bit 3.
- R4: Next come 0xA8 and then `rows`-1, followed by 0xD3 and then `com_offset`.
- R5: Next come 0xD5 and then a byte holding (`clk_div`-1) in bits 3:0 and `clk_freq` in bits 7:4.
- R6: The pair 0xD8 plus an option byte is sent only when `area_color` or `low_power` is set. The option is 0x1E for area colour OR 0x05 for low power.
- R7: Next come 0xD9 and then `pre1` in bits 3:0 and `pre2` in bits 7:4.
- R8: Next come 0xDA and then a byte with bit 1 set, bit 4 equal to NOT `com_seq`, and bit 5 equal to `com_lr_remap`.
- R9: Next come 0xDB and `vcomh`, then 0x8D and 0x10, with bit 2 also set when `need_pump` is high.
- R10: The stream ends with 0x20 and then 0x02 (`page_mode`=1) or 0x00 (`page_mode`=0). `done` rises after this last byte is accepted and stays high until the next accepted start.
- R11: An offered byte holds `tx_data` stable until `tx_ready` is sampled high, and `tx_is_cmd` is high with every offered byte.
- R12: A start pulse during a running sequence is ignored: there is no second reset pulse and no change to the stream.
- R13: When idle, `disp_on_req` sends the single byte 0xAF and `disp_off_req` sends 0xAE. Off wins when both are requested. Both requests are ignored while a sequence runs, and a request at the same time as start loses to start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse for reset and configuration |
| disp_on_req | input | 1 | Request the display-on command |
| disp_off_req | input | 1 | Request the display-off command |
| contrast | input | 8 | Contrast level (typically 127) |
| seg_remap | input | 1 | Segment remap flag |
| com_invert | input | 1 | COM scan invert flag |
| rows | input | 8 | Panel height in rows (1..64) |
| com_offset | input | 8 | COM display offset |
| clk_div | input | 5 | Display clock divider (1..16) |
| clk_freq | input | 4 | Oscillator frequency code |
| area_color | input | 1 | Area colour enable |
| low_power | input | 1 | Low-power display enable |
| pre1 | input | 4 | Precharge phase 1 (typically 2) |
| pre2 | input | 4 | Precharge phase 2 (typically 2) |
| com_seq | input | 1 | Sequential COM pin layout |
| com_lr_remap | input | 1 | COM left/right remap |
| vcomh | input | 8 | VCOMH level |
| need_pump | input | 1 | Charge pump required |
| page_mode | input | 1 | 1: page addressing, 0: horizontal |
| tx_ready | input | 1 | Downstream accepts the offered byte |
| tx_valid | output | 1 | A byte is offered |
| tx_data | output | 8 | Offered byte |
| tx_is_cmd | output | 1 | Offered byte is a command byte |
| panel_rst | output | 1 | Active-high panel reset |
| done | output | 1 | Configuration finished |

## Verification
The assertions assume that the configuration inputs stay constant from an accepted start until `done` rises. They also assume that the sink may hold `tx_ready` low for any number of cycles but never withdraws an accepted byte. The bench changes configuration only while the block is idle. It drives `tx_ready` either constantly high or from a pseudo-random stall pattern. It asserts start and display requests for one cycle, either while idle or in the middle of a run to exercise the ignore rules.

// File: rtl/oled_cfg_seq.sv
module oled_cfg_seq #(
  parameter int RST_CYCLES = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       disp_on_req,
  input  logic       disp_off_req,
  input  logic [7:0] contrast,
  input  logic       seg_remap,
  input  logic       com_invert,
  input  logic [7:0] rows,
  input  logic [7:0] com_offset,
  input  logic [4:0] clk_div,
  input  logic [3:0] clk_freq,
  input  logic       area_color,
  input  logic       low_power,
  input  logic [3:0] pre1,
  input  logic [3:0] pre2,
  input  logic       com_seq,
  input  logic       com_lr_remap,
  input  logic [7:0] vcomh,
  input  logic       need_pump,
  input  logic       page_mode,
  input  logic       tx_ready,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  output logic       tx_is_cmd,
  output logic       panel_rst,
  output logic       done
);
  localparam int CW        = $clog2(RST_CYCLES + 1);
  localparam int LAST_STEP = 21;
  localparam int SKIP_FROM = 9;
  localparam int SKIP_TO   = 12;

  typedef enum logic [2:0] {S_IDLE, S_RHI, S_RLO, S_SEND, S_ONE} state_t;

  state_t     state;
  logic [CW-1:0] cnt;
  logic [4:0] step;
  logic [7:0] one_byte;
  logic [7:0] cfg_byte;
  logic [4:0] div_m1;
  logic       acm_on;
  logic       hs;

  assign div_m1    = clk_div - 5'd1;
  assign acm_on    = area_color | low_power;
  assign tx_valid  = (state == S_SEND) || (state == S_ONE);
  assign tx_data   = (state == S_ONE) ? one_byte : cfg_byte;
  assign tx_is_cmd = tx_valid;
  assign panel_rst = (state == S_RHI);
  assign hs        = tx_valid & tx_ready;

  always_comb begin
    case (step)
      5'd0:    cfg_byte = 8'h81;
      5'd1:    cfg_byte = contrast;
      5'd2:    cfg_byte = {7'b1010000, seg_remap};
      5'd3:    cfg_byte = {4'hC, com_invert, 3'b000};
      5'd4:    cfg_byte = 8'hA8;
      5'd5:    cfg_byte = rows - 8'd1;
      5'd6:    cfg_byte = 8'hD3;
      5'd7:    cfg_byte = com_offset;
      5'd8:    cfg_byte = 8'hD5;
      5'd9:    cfg_byte = {clk_freq, div_m1[3:0]};
      5'd10:   cfg_byte = 8'hD8;
      5'd11:   cfg_byte = (area_color ? 8'h1E : 8'h00) | (low_power ? 8'h05 : 8'h00);
      5'd12:   cfg_byte = 8'hD9;
      5'd13:   cfg_byte = {pre2, pre1};
      5'd14:   cfg_byte = 8'hDA;
      5'd15:   cfg_byte = {2'b00, com_lr_remap, ~com_seq, 4'b0010};
      5'd16:   cfg_byte = 8'hDB;
      5'd17:   cfg_byte = vcomh;
      5'd18:   cfg_byte = 8'h8D;
      5'd19:   cfg_byte = {5'b00010, need_pump, 2'b00};
      5'd20:   cfg_byte = 8'h20;
      default: cfg_byte = page_mode ? 8'h02 : 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      step     <= '0;
      one_byte <= 8'h00;
      done     <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (start) begin
            state <= S_RHI;
            cnt   <= '0;
            done  <= 1'b0;
          end else if (disp_off_req || disp_on_req) begin
            state    <= S_ONE;
            one_byte <= disp_off_req ? 8'hAE : 8'hAF;
          end
        end
        S_RHI, S_RLO: begin
          if (cnt == CW'(RST_CYCLES - 1)) begin
            cnt   <= '0;
            step  <= '0;
            state <= (state == S_RHI) ? S_RLO : S_SEND;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_SEND: begin
          if (hs) begin
            if (step == 5'(LAST_STEP)) begin
              state <= S_IDLE;
              done  <= 1'b1;
            end else if (step == 5'(SKIP_FROM) && !acm_on) begin
              step <= 5'(SKIP_TO);
            end else begin
              step <= step + 5'd1;
            end
          end
        end
        S_ONE: if (hs) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/oled_cfg_seq_chk.sv
module oled_cfg_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       panel_rst,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_data,
  input logic       tx_is_cmd,
  input logic       done
);
  a_r1_no_byte_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    panel_rst |-> !tx_valid);

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(panel_rst) |-> (!tx_valid && !done));

  a_r11_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  a_r11_cmd_flag: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> tx_is_cmd);

  a_r10_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(tx_valid && tx_ready && (tx_data == 8'h00 || tx_data == 8'h02)));

  a_r10_done_not_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !panel_rst);
endmodule

bind oled_cfg_seq oled_cfg_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .panel_rst(panel_rst), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .tx_data(tx_data), .tx_is_cmd(tx_is_cmd), .done(done)
);

// File: tb/tb_oled_cfg_seq.sv
module tb_oled_cfg_seq;
  localparam int CLK_PERIOD = 10;
  localparam int RSTC = 6;

  logic clk = 0, rst_n = 0, start = 0, disp_on_req = 0, disp_off_req = 0;
  logic [7:0] contrast, rows, com_offset, vcomh;
  logic seg_remap, com_invert, area_color, low_power, com_seq, com_lr_remap, need_pump, page_mode;
  logic [4:0] clk_div;
  logic [3:0] clk_freq, pre1, pre2;
  logic tx_ready = 1;
  logic tx_valid, tx_is_cmd, panel_rst, done;
  logic [7:0] tx_data;

  int errors = 0, checks = 0, cycles = 0;
  bit stall = 0;
  logic [7:0] lfsr = 8'hA5;

  logic [7:0] cap [0:63];
  int cap_n = 0, rst_rises = 0;
  bit flag_bad = 0, hold_bad = 0, prev_stall = 0;
  logic [7:0] prev_data, prev_rst = 0;

  logic [7:0] exp_b [0:31];
  string exp_t [0:31];
  int exp_n;

  oled_cfg_seq #(.RST_CYCLES(RSTC)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    tx_ready <= stall ? lfsr[0] : 1'b1;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst_n) begin
      if (tx_valid && tx_ready) begin
        cap[cap_n[5:0]] <= tx_data;
        cap_n <= cap_n + 1;
        if (!tx_is_cmd) flag_bad <= 1;
      end
      if (prev_stall && (!tx_valid || tx_data != prev_data)) hold_bad <= 1;
      prev_stall <= tx_valid && !tx_ready;
      prev_data  <= tx_data;
      if (panel_rst && !prev_rst[0]) rst_rises <= rst_rises + 1;
      prev_rst[0] <= panel_rst;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  task automatic push(input logic [7:0] b, input string t);
    exp_b[exp_n] = b; exp_t[exp_n] = t; exp_n++;
  endtask

  task automatic build();
    exp_n = 0;
    push(8'h81, "R2"); push(contrast, "R2");
    push(8'hA0 | {7'd0, seg_remap}, "R3"); push(8'hC0 | {4'd0, com_invert, 3'd0}, "R3");
    push(8'hA8, "R4"); push(rows - 8'd1, "R4"); push(8'hD3, "R4"); push(com_offset, "R4");
    push(8'hD5, "R5"); push({clk_freq, 4'((clk_div - 5'd1))}, "R5");
    if (area_color || low_power) begin
      push(8'hD8, "R6");
      push((area_color ? 8'h1E : 8'h00) | (low_power ? 8'h05 : 8'h00), "R6");
    end
    push(8'hD9, "R7"); push({pre2, pre1}, "R7");
    push(8'hDA, "R8"); push(8'h02 | (com_seq ? 8'h00 : 8'h10) | (com_lr_remap ? 8'h20 : 8'h00), "R8");
    push(8'hDB, "R9"); push(vcomh, "R9"); push(8'h8D, "R9"); push(need_pump ? 8'h14 : 8'h10, "R9");
    push(8'h20, "R10"); push(page_mode ? 8'h02 : 8'h00, "R10");
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
  endtask

  task automatic run_config(input bit disturb);
    int hi = 0, lo = 0;
    build();
    cap_n = 0; rst_rises = 0;
    @(negedge clk) start = 1; disp_on_req = disturb;
    @(negedge clk) start = 0; disp_on_req = 0;
    check(done == 0, "R10 done cleared by start", done, 0);
    while (panel_rst) begin hi++; @(negedge clk); end
    check(hi == RSTC, "R1 reset high cycles", hi, RSTC);
    while (!panel_rst && !tx_valid) begin lo++; @(negedge clk); end
    check(lo == RSTC, "R1 reset low cycles", lo, RSTC);
    if (disturb) begin
      while (cap_n < 5) @(negedge clk);
      pulse_start();
      @(negedge clk) disp_off_req = 1;
      @(negedge clk) disp_off_req = 0;
    end
    while (!done) @(negedge clk);
    repeat (8) @(negedge clk);
    check(cap_n == exp_n, "R6 R12 byte count", cap_n, exp_n);
    for (int i = 0; i < exp_n; i++)
      check(cap[i] == exp_b[i], exp_t[i], cap[i], exp_b[i]);
    check(rst_rises == 1, "R12 single reset pulse", rst_rises, 1);
    check(done == 1 && !tx_valid, "R10 done held idle", {done, tx_valid}, 2);
    check(!flag_bad && !hold_bad, "R11 flag and hold", {flag_bad, hold_bad}, 0);
  endtask

  task automatic disp_req(input bit on, input bit off, input logic [7:0] expb, input string tag);
    cap_n = 0;
    @(negedge clk) disp_on_req = on; disp_off_req = off;
    @(negedge clk) disp_on_req = 0; disp_off_req = 0;
    repeat (6) @(negedge clk);
    check(cap_n == 1, {tag, " single byte"}, cap_n, 1);
    check(cap[0] == expb, tag, cap[0], expb);
    check(!panel_rst && done, {tag, " no sequence"}, {panel_rst, done}, 1);
  endtask

  initial begin : watchdog
    wait (cycles > 100000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    contrast = 8'd127; seg_remap = 0; com_invert = 0; rows = 8'd64; com_offset = 0;
    clk_div = 5'd1; clk_freq = 4'd8; area_color = 0; low_power = 0; pre1 = 2; pre2 = 2;
    com_seq = 1; com_lr_remap = 0; vcomh = 8'h20; need_pump = 0; page_mode = 0;
    repeat (3) @(negedge clk);
    check(!panel_rst && !tx_valid && !done, "R1 reset state", {panel_rst, tx_valid, done}, 0);
    rst_n = 1;
    @(negedge clk);

    run_config(0);

    stall = 1;
    contrast = 8'h3C; seg_remap = 1; com_invert = 1; rows = 8'd32; com_offset = 8'd7;
    clk_div = 5'd16; clk_freq = 4'hC; area_color = 1; low_power = 1; pre1 = 4'h1; pre2 = 4'hF;
    com_seq = 0; com_lr_remap = 1; vcomh = 8'h34; need_pump = 1; page_mode = 1;
    run_config(1);

    stall = 0;
    area_color = 0; low_power = 1; rows = 8'd16; clk_div = 5'd2;
    run_config(0);
    area_color = 1; low_power = 0;
    run_config(0);

    disp_req(1, 0, 8'hAF, "R13 display on");
    disp_req(0, 1, 8'hAE, "R13 display off");
    disp_req(1, 1, 8'hAE, "R13 off wins");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule